// File: doc/BRIEF.md
# SECDED Protected Memory Wrapper

This block puts single-error-correct, double-error-detect protection around a word-wide synchronous RAM. Every 32-bit word is kept together with 7 check bits: six Hamming bits and one parity bit over the whole word. The requester side has an enable, a write strobe, per-byte write enables, an address, write data and a ready signal. Read data comes back one cycle after the read is accepted, with the check bits removed and any single-bit fault corrected.

A write that enables all four bytes is encoded and stored in the cycle it is accepted. A write that enables only some of the bytes becomes an internal sequence. The stored word is read and corrected. The new bytes are merged in, and the result is encoded again and written back. Ready stays low for the two cycles this sequence needs. Every decode that finds a fault raises one of two single-cycle event outputs, correctable or uncorrectable. The same decode also appends an entry to a small circular log, which holds the address and a fault-type bit. A second index port reads the log at any time. A fault-injection mask can flip chosen bits of the codeword that a write stores, so that both error paths can be tested.

Top module: `secded_mem_top`

## Requirements
- R1: A read accepted at a clock edge (req_en high while req_ready is high, req_we low) raises rsp_valid for exactly the following cycle. In that cycle rsp_rdata holds the word stored at that address. A full write (req_be = 4'b1111) stores req_wdata, and a read in the next cycle already returns it.
- R2: A read of a word that holds no flipped bits raises neither ce_pulse nor ue_pulse.
- R3: A read of a word with exactly one flipped bit returns the data as originally written and raises ce_pulse in the response cycle. The flipped bit may be any of the 39 stored bits: stored bits 31:0 are data bit i, bits 37:32 are the Hamming bits and bit 38 is the overall parity.
- R4: A read of a word with exactly two flipped bits raises ue_pulse and not ce_pulse. rsp_rdata then returns the stored data bits uncorrected. ce_pulse and ue_pulse are never high together.
- R5: A write with one to three byte enables set is accepted and merges the new bytes into the stored word. Byte k covers data bits 8k+7:8k. req_ready is low for exactly the two cycles after acceptance and high again in the third. The bytes not enabled keep their stored values.
- R6: A write with req_be = 4'b0000 changes no stored word, including when injection is enabled. It raises no pulse, and req_ready stays high.
- R7: If the internal read of a partial write finds a fault, the corresponding pulse rises in the cycle after acceptance and the fault is logged. A single fault is corrected before the merge. After a double fault the raw stored bytes are merged.
- R8: Each pulse writes one log entry at log_wptr, in the cycle after the pulse, and log_wptr then advances by one modulo 2^LOG_AW. An entry holds the word address and a type bit, 1 for uncorrectable and 0 for correctable. Log position log_idx is presented on log_entry_ue and log_entry_addr.
- R9: log_ovf rises together with the pointer wrap caused by a log write at the last position. It then stays high until reset.
- R10: Under reset req_ready is 1 and rsp_valid, ce_pulse, ue_pulse, log_wptr, log_ovf and all log entries are 0.
- R11: When inj_en is high with an accepted write, the codeword stored is the encoded word XOR inj_mask. For a partial write this applies to the write-back. When inj_en is low, inj_mask has no effect.
- R12: A read can be accepted on every cycle, and each one produces its own response in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_en | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte write enables |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted when high together with req_en |
| inj_en | input | 1 | Apply inj_mask to the codeword being written |
| inj_mask | input | 39 | Codeword bits to flip |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Corrected read data |
| ce_pulse | output | 1 | Correctable fault found |
| ue_pulse | output | 1 | Uncorrectable fault found |
| log_idx | input | LOG_AW | Log position to present |
| log_entry_ue | output | 1 | Type bit of the selected entry |
| log_entry_addr | output | ADDR_W | Address of the selected entry |
| log_wptr | output | LOG_AW | Next log write position |
| log_ovf | output | 1 | Sticky log wrap flag |

## Verification
The main function is driven with clean words, with single flips placed in a data bit, a Hamming bit and the overall parity bit, and with double flips that hit two data bits or a data bit and a check bit. These cases separate correction from detection and confirm that a fault in a check bit leaves the data untouched. Partial writes are issued over clean, singly corrupted and doubly corrupted words, and some of them inject a fresh fault into the write-back. This shows whether the merge uses the corrected bytes, the raw bytes or the new bytes. Back-to-back reads, an all-zero byte-enable write and a long run of faulty reads exercise pipelining, the ignored case and the wrap of the log.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
// Shared code parameters, codeword type and the SECDED encode helpers.
// Assumes a 32-bit data word; positions 1..38 form the Hamming codeword,
// powers of two are check positions, the rest carry data bits in order.
package secded_pkg;

    localparam int DW     = 32;            // data bits per word
    localparam int HW     = 6;             // Hamming check bits
    localparam int CW     = HW + 1;        // stored check bits (with overall parity)
    localparam int WW     = DW + CW;       // stored codeword width
    localparam int BEW    = DW / 8;        // byte enables
    localparam int MAXPOS = DW + HW;       // highest Hamming position

    // Stored word: data in the low bits, check bits above
    typedef struct packed {
        logic [CW-1:0] chk;
        logic [DW-1:0] data;
    } cword_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_WBACK = 2'd2
    } wrap_state_e;

    // Hamming position occupied by data bit idx
    function automatic int data_pos(input int idx);
        int cnt = 0;
        int res = 0;
        for (int k = 1; k <= MAXPOS; k++) begin
            if ((k & (k - 1)) != 0) begin
                if (cnt == idx) res = k;
                cnt++;
            end
        end
        return res;
    endfunction

    // Hamming check bits of a data word
    function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
        logic [HW-1:0] h = '0;
        logic [HW-1:0] pv;
        for (int i = 0; i < DW; i++) begin
            pv = HW'(data_pos(i));
            for (int b = 0; b < HW; b++) begin
                if (pv[b]) h[b] = h[b] ^ d[i];
            end
        end
        return h;
    endfunction

    // Full codeword: Hamming bits plus overall parity on top
    function automatic cword_t secded_encode(input logic [DW-1:0] d);
        cword_t w;
        logic [HW-1:0] h;
        h      = ham_bits(d);
        w.data = d;
        w.chk  = {^{h, d}, h};
        return w;
    endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
// Encodes a data word into its stored codeword and applies a flip mask.
// Assumes the mask is already zero when no fault injection is wanted.
module secded_enc
    import secded_pkg::*;
(
    input  logic [DW-1:0] data_i,
    input  logic [WW-1:0] flip_i,
    output cword_t        word_o
);

    // Encode, then corrupt the chosen bits
    always_comb begin
        word_o = secded_encode(data_i) ^ flip_i;
    end

endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
// Checks a stored codeword, corrects one flipped data bit and classifies
// the result. Assumes at most two bits are flipped; a syndrome beyond the
// last valid position with odd parity is treated as uncorrectable.
module secded_dec
    import secded_pkg::*;
(
    input  cword_t        word_i,
    output logic [DW-1:0] data_o,
    output logic          single_o,
    output logic          double_o
);

    logic [HW-1:0] syn;
    logic          par_odd;
    logic          in_range;

    // Syndrome and overall parity
    always_comb begin
        syn      = ham_bits(word_i.data) ^ word_i.chk[HW-1:0];
        par_odd  = ^word_i;
        in_range = (syn <= HW'(MAXPOS));
        single_o = par_odd & in_range;
        double_o = (~par_odd & (|syn)) | (par_odd & ~in_range);
    end

    // Flip the data bit the syndrome points at; check-bit faults leave data alone
    always_comb begin
        data_o = word_i.data;
        for (int i = 0; i < DW; i++) begin
            if (single_o && (syn == HW'(data_pos(i)))) data_o[i] = ~word_i.data[i];
        end
    end

endmodule

// File: rtl/secded_store.sv
`timescale 1ns/1ps
// Single-port synchronous codeword RAM with a registered read.
// Assumes at most one access per cycle; contents are not reset.
module secded_store
    import secded_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  cword_t        wdata_i,
    output cword_t        rdata_o
);

    localparam int DEPTH = 1 << AW;

    cword_t mem [DEPTH];

    // Write or registered read
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) mem[addr_i] <= wdata_i;
            else      rdata_o     <= mem[addr_i];
        end
    end

endmodule

// File: rtl/ecc_fault_log.sv
`timescale 1ns/1ps
// Circular log of detected faults: word address plus a type bit.
// Assumes one push per cycle at most; the wrap flag is sticky until reset.
module ecc_fault_log #(
    parameter int AW     = 8,
    parameter int LOG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              push_ue_i,
    input  logic [AW-1:0]     push_addr_i,
    input  logic [LOG_AW-1:0] rd_idx_i,
    output logic              rd_ue_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic [LOG_AW-1:0] wptr_o,
    output logic              ovf_o
);

    localparam int                DEPTH = 1 << LOG_AW;
    localparam logic [LOG_AW-1:0] LAST  = LOG_AW'(DEPTH - 1);

    logic              ent_ue   [DEPTH];
    logic [AW-1:0]     ent_addr [DEPTH];

    // Entry storage, write pointer and wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_ue[i]   <= 1'b0;
                ent_addr[i] <= '0;
            end
            wptr_o <= '0;
            ovf_o  <= 1'b0;
        end else if (push_i) begin
            ent_ue[wptr_o]   <= push_ue_i;
            ent_addr[wptr_o] <= push_addr_i;
            wptr_o           <= wptr_o + 1'b1;
            if (wptr_o == LAST) ovf_o <= 1'b1;
        end
    end

    // Read-out of the selected entry
    always_comb begin
        rd_ue_o   = ent_ue[rd_idx_i];
        rd_addr_o = ent_addr[rd_idx_i];
    end

endmodule

// File: rtl/secded_mem_top.sv
`timescale 1ns/1ps
// SECDED protected memory wrapper. Full writes are stored in one cycle,
// reads answer one cycle later, partial writes run read/merge/write-back
// with ready held low for two cycles. Every decode that finds a fault
// pulses an event output and appends to the fault log.
// Assumes the requester only counts a request as taken when ready is high.
module secded_mem_top
    import secded_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LOG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              req_we,
    input  logic [BEW-1:0]    req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_ready,
    input  logic              inj_en,
    input  logic [WW-1:0]     inj_mask,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              ce_pulse,
    output logic              ue_pulse,
    input  logic [LOG_AW-1:0] log_idx,
    output logic              log_entry_ue,
    output logic [ADDR_W-1:0] log_entry_addr,
    output logic [LOG_AW-1:0] log_wptr,
    output logic              log_ovf
);

    wrap_state_e       state;
    logic              rd_pend_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [BEW-1:0]    be_q;
    logic [DW-1:0]     wdata_q;
    logic [WW-1:0]     flip_q;
    logic [DW-1:0]     merged_q;

    logic              accept;
    logic              is_full;
    logic              is_part;
    logic              dec_valid;
    logic [WW-1:0]     new_flip;
    cword_t            new_word;
    cword_t            wb_word;
    cword_t            ram_wdata;
    cword_t            ram_q;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DW-1:0]     dec_data;
    logic              dec_single;
    logic              dec_double;
    logic [DW-1:0]     merge_word;

    // Request classification
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_en & req_ready;
        is_full   = req_we & (&req_be);
        is_part   = req_we & (|req_be) & ~(&req_be);
        new_flip  = inj_en ? inj_mask : '0;
        dec_valid = rd_pend_q | (state == ST_MERGE);
    end

    secded_enc u_enc_new (
        .data_i (req_wdata),
        .flip_i (new_flip),
        .word_o (new_word)
    );

    secded_enc u_enc_wb (
        .data_i (merged_q),
        .flip_i (flip_q),
        .word_o (wb_word)
    );

    // RAM port steering: write-back owns the port outside idle
    always_comb begin
        if (state == ST_WBACK) begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = op_addr_q;
            ram_wdata = wb_word;
        end else begin
            ram_en    = accept & (~req_we | is_full | is_part);
            ram_we    = accept & is_full;
            ram_addr  = req_addr;
            ram_wdata = new_word;
        end
    end

    secded_store #(.AW(ADDR_W)) u_store (
        .clk     (clk),
        .en_i    (ram_en),
        .we_i    (ram_we),
        .addr_i  (ram_addr),
        .wdata_i (ram_wdata),
        .rdata_o (ram_q)
    );

    secded_dec u_dec (
        .word_i   (ram_q),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    // Byte merge of new data over the decoded stored word
    for (genvar k = 0; k < BEW; k++) begin : g_merge
        assign merge_word[8*k +: 8] = be_q[k] ? wdata_q[8*k +: 8] : dec_data[8*k +: 8];
    end

    // Sequencer and operation capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_pend_q <= 1'b0;
            op_addr_q <= '0;
            be_q      <= '0;
            wdata_q   <= '0;
            flip_q    <= '0;
            merged_q  <= '0;
        end else begin
            rd_pend_q <= accept & ~req_we;
            if (accept & (~req_we | is_part)) op_addr_q <= req_addr;
            case (state)
                ST_IDLE: begin
                    if (accept & is_part) begin
                        be_q    <= req_be;
                        wdata_q <= req_wdata;
                        flip_q  <= new_flip;
                        state   <= ST_MERGE;
                    end
                end
                ST_MERGE: begin
                    merged_q <= merge_word;
                    state    <= ST_WBACK;
                end
                ST_WBACK: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Response and event outputs
    always_comb begin
        rsp_valid = rd_pend_q;
        rsp_rdata = dec_data;
        ce_pulse  = dec_valid & dec_single;
        ue_pulse  = dec_valid & dec_double;
    end

    ecc_fault_log #(.AW(ADDR_W), .LOG_AW(LOG_AW)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (ce_pulse | ue_pulse),
        .push_ue_i   (ue_pulse),
        .push_addr_i (op_addr_q),
        .rd_idx_i    (log_idx),
        .rd_ue_o     (log_entry_ue),
        .rd_addr_o   (log_entry_addr),
        .wptr_o      (log_wptr),
        .ovf_o       (log_ovf)
    );

endmodule

// File: rtl/secded_mem_chk.sv
`timescale 1ns/1ps
// Temporal checks on the wrapper's ports, attached by bind.
// Assumes the top's default parameters are passed through.
module secded_mem_chk
    import secded_pkg::*;
#(
    parameter int LOG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_en,
    input logic              req_we,
    input logic [BEW-1:0]    req_be,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              ce_pulse,
    input logic              ue_pulse,
    input logic [LOG_AW-1:0] log_wptr,
    input logic              log_ovf
);

    p_rd_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_ready && !req_we) |=> rsp_valid);

    p_resp_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_en && req_ready && !req_we));

    p_excl_pulses_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse && ue_pulse));

    p_rmw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_ready && req_we && (|req_be) && !(&req_be))
        |=> !req_ready ##1 !req_ready ##1 req_ready);

    p_none_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_ready && req_we && (req_be == '0)) |=> (req_ready && !rsp_valid));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_pulse || ue_pulse) |=> (log_wptr == LOG_AW'($past(log_wptr) + 1'b1)));

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_pulse || ue_pulse) |=> $stable(log_wptr));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        log_ovf |=> log_ovf);

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ce_pulse || ue_pulse) && (&log_wptr)) |=> log_ovf);

endmodule

bind secded_mem_top secded_mem_chk #(.LOG_AW(LOG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_en    (req_en),
    .req_we    (req_we),
    .req_be    (req_be),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ce_pulse  (ce_pulse),
    .ue_pulse  (ue_pulse),
    .log_wptr  (log_wptr),
    .log_ovf   (log_ovf)
);

// File: tb/tb_secded_mem_top.sv
`timescale 1ns/1ps
module tb_secded_mem_top;

    localparam int AW    = 8;
    localparam int LAW   = 3;
    localparam int LDEP  = 1 << LAW;
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_en = 1'b0;
    logic           req_we = 1'b0;
    logic [3:0]     req_be = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic           req_ready;
    logic           inj_en = 1'b0;
    logic [38:0]    inj_mask = '0;
    logic           rsp_valid;
    logic [31:0]    rsp_rdata;
    logic           ce_pulse;
    logic           ue_pulse;
    logic [LAW-1:0] log_idx = '0;
    logic           log_entry_ue;
    logic [AW-1:0]  log_entry_addr;
    logic [LAW-1:0] log_wptr;
    logic           log_ovf;

    secded_mem_top #(.ADDR_W(AW), .LOG_AW(LAW)) dut (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_we(req_we),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .inj_en(inj_en), .inj_mask(inj_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ce_pulse(ce_pulse),
        .ue_pulse(ue_pulse), .log_idx(log_idx), .log_entry_ue(log_entry_ue),
        .log_entry_addr(log_entry_addr), .log_wptr(log_wptr), .log_ovf(log_ovf)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R10";

    // Reference model state
    logic [31:0]    m_data [DEPTH];
    logic [38:0]    m_flip [DEPTH];
    logic           m_lue  [LDEP];
    logic [AW-1:0]  m_laddr[LDEP];
    int             mst;
    logic           e_ready, e_valid, e_ce, e_ue, e_ovf;
    logic [31:0]    e_rdata;
    logic [LAW-1:0] e_wptr;
    string          e_tag;
    logic           p_push, p_ue;
    logic [AW-1:0]  p_addr;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] %s act=%0h exp=%0h", rq, cur_tag, what, act, exp);
        end
    endtask

    // Classify the stored word at a; returns the data seen after decode
    function automatic logic [31:0] classify(input logic [AW-1:0] a);
        int n = $countones(m_flip[a]);
        e_ce = (n == 1);
        e_ue = (n == 2);
        if (n != 0) begin
            p_push = 1'b1;
            p_ue   = (n == 2);
            p_addr = a;
        end
        return (n == 2) ? (m_data[a] ^ m_flip[a][31:0]) : m_data[a];
    endfunction

    // Cycle model, advanced at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; e_ready = 1; e_valid = 0; e_ce = 0; e_ue = 0;
            e_ovf = 0; e_wptr = '0; e_rdata = '0; e_tag = "R1";
            p_push = 0; p_ue = 0; p_addr = '0;
            for (int i = 0; i < LDEP; i++) begin m_lue[i] = 0; m_laddr[i] = '0; end
        end else begin
            if (p_push) begin
                m_lue[e_wptr] = p_ue; m_laddr[e_wptr] = p_addr;
                if (e_wptr == LAW'(LDEP - 1)) e_ovf = 1;
                e_wptr = e_wptr + 1'b1;
            end
            p_push = 0; e_valid = 0; e_ce = 0; e_ue = 0;
            case (mst)
                0: if (req_en) begin
                    if (!req_we) begin
                        e_rdata = classify(req_addr);
                        e_valid = 1;
                        e_tag   = e_ue ? "R4" : (e_ce ? "R3" : "R1");
                    end else if (req_be == 4'hF) begin
                        m_data[req_addr] = req_wdata;
                        m_flip[req_addr] = inj_en ? inj_mask : '0;
                    end else if (req_be != 4'h0) begin
                        logic [31:0] base;
                        base = classify(req_addr);
                        for (int k = 0; k < 4; k++)
                            if (req_be[k]) base[8*k +: 8] = req_wdata[8*k +: 8];
                        m_data[req_addr] = base;
                        m_flip[req_addr] = inj_en ? inj_mask : '0;
                        mst = 1;
                    end
                end
                1: mst = 2;
                default: mst = 0;
            endcase
            e_ready = (mst == 0);
        end
    end

    // Compare every cycle, away from the edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(req_ready === e_ready, "R5", "ready", 64'(req_ready), 64'(e_ready));
            chk(rsp_valid === e_valid, "R1", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
            if (e_valid)
                chk(rsp_rdata === e_rdata, e_tag, "rdata", 64'(rsp_rdata), 64'(e_rdata));
            chk(ce_pulse === e_ce, "R3", "ce_pulse", 64'(ce_pulse), 64'(e_ce));
            chk(ue_pulse === e_ue, "R4", "ue_pulse", 64'(ue_pulse), 64'(e_ue));
            chk(log_wptr === e_wptr, "R8", "log_wptr", 64'(log_wptr), 64'(e_wptr));
            chk(log_ovf === e_ovf, "R9", "log_ovf", 64'(log_ovf), 64'(e_ovf));
            chk({log_entry_ue, log_entry_addr} === {m_lue[log_idx], m_laddr[log_idx]},
                "R8", "log entry", 64'({log_entry_ue, log_entry_addr}),
                64'({m_lue[log_idx], m_laddr[log_idx]}));
        end
    end

    task automatic op(input logic we, input logic [3:0] be, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic inj, input logic [38:0] m,
                      input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag = tag;
        req_en = 1; req_we = we; req_be = be; req_addr = a; req_wdata = d;
        inj_en = inj; inj_mask = m;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        op(1'b0, 4'h0, a, 32'h0, 1'b0, 39'h0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_en = 0; inj_en = 0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        #1;
        // R10: values held under reset
        chk(req_ready === 1'b1, "R10", "ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0, "R10", "valid in reset", 64'(rsp_valid), 64'd0);
        chk({ce_pulse, ue_pulse} === 2'b00, "R10", "pulses in reset", 64'({ce_pulse, ue_pulse}), 64'd0);
        chk(log_wptr === '0, "R10", "wptr in reset", 64'(log_wptr), 64'd0);
        chk(log_ovf === 1'b0, "R10", "ovf in reset", 64'(log_ovf), 64'd0);
        chk({log_entry_ue, log_entry_addr} === '0, "R10", "entry in reset", 64'(log_entry_addr), 64'd0);
        @(negedge clk);
        rst_n = 1;

        for (int i = 0; i < 8; i++)
            op(1'b1, 4'hF, AW'(i), 32'h9E37_79B9 * (i + 1), 1'b0, 39'h0, "R1");
        for (int i = 0; i < 8; i++) rd(AW'(i), "R12");      // back-to-back, also R2
        idle(2);

        op(1'b1, 4'hF, 8'd1, 32'hCAFE_F00D, 1'b1, 39'h1 << 5,  "R11");
        op(1'b1, 4'hF, 8'd2, 32'h0F0F_3C3C, 1'b1, 39'h1 << 33, "R11");
        op(1'b1, 4'hF, 8'd3, 32'hFFFF_0000, 1'b1, 39'h1 << 38, "R11");
        op(1'b1, 4'hF, 8'd4, 32'h1357_9BDF, 1'b1, (39'h1 << 0) | (39'h1 << 31), "R11");
        op(1'b1, 4'hF, 8'd5, 32'h2468_ACE0, 1'b1, (39'h1 << 10) | (39'h1 << 35), "R11");
        rd(8'd1, "R3"); rd(8'd2, "R3"); rd(8'd3, "R3");
        rd(8'd4, "R4"); rd(8'd5, "R4");
        rd(8'd0, "R2");
        idle(2);

        op(1'b1, 4'b0010, 8'd1, 32'hAAAA_55AA, 1'b0, 39'h0, "R7");
        op(1'b1, 4'b0001, 8'd4, 32'h0000_00EE, 1'b0, 39'h0, "R7");
        op(1'b1, 4'b1100, 8'd6, 32'h7788_0000, 1'b1, 39'h1 << 20, "R11");
        op(1'b1, 4'b0101, 8'd7, 32'h00C3_00C3, 1'b0, 39'h0, "R5");
        rd(8'd1, "R5"); rd(8'd4, "R7"); rd(8'd6, "R11"); rd(8'd7, "R5");
        op(1'b1, 4'h0, 8'd0, 32'hDEAD_BEEF, 1'b1, 39'h3, "R6");
        rd(8'd0, "R6");
        op(1'b1, 4'hF, 8'd8, 32'h5555_AAAA, 1'b0, 39'h7F, "R11");
        rd(8'd8, "R11");
        idle(2);

        for (int i = 0; i < 10; i++) rd(8'd2, "R9");
        idle(3);
        for (int i = 0; i < LDEP; i++) begin
            @(negedge clk);
            req_en = 0; cur_tag = "R8"; log_idx = LAW'(i);
            idle(1);
        end
        idle(2);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule